// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns a memory-reference instruction of a 12-bit single-accumulator machine into the final operand address within a 4096-word memory. The seven low bits of the instruction select a word inside a 128-word page. A page-select bit chooses between page zero and the page that holds the current instruction. An indirect bit makes the block fetch a pointer from the formed address and use that pointer as the operand address.

Eight absolute locations in low memory act as index pointers. An indirect reference through one of them makes the block read the pointer, add one to it, write the new value back, and then deliver the new value. The block talks to a plain synchronous memory port, where read data appears in the cycle after the read strobe. It reports the result with a one-cycle done strobe.

A controller presents an instruction and the address of that instruction together with a valid strobe. Requests whose opcode is not a memory-reference opcode are dropped. So are requests that arrive while the block is busy.

Top module: `paged_ea_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, req_ready is 1 and done, mem_re and mem_we are all 0.
- R2: A request whose opcode field instr[11:9] is 6 or 7 is ignored. done is never raised, no memory cycle is issued, and req_ready stays 1.
- R3: When the page bit instr[7] is 0, the formed address is instr[6:0] with bits [11:7] equal to zero.
- R4: When instr[7] is 1, the formed address is {pc[11:7], instr[6:0]}, taken from the pc given with the request. This holds when that pc is the last word of its page.
- R5: When the indirect bit instr[8] is 0, done rises in the first cycle after the request is accepted, with ea equal to the formed address and no memory cycle.
- R6: When instr[8] is 1 and the formed address is outside 8..15, the block issues exactly one read at the formed address and no write. done rises three cycles after acceptance, with ea equal to the word read.
- R7: When instr[8] is 1 and the formed address lies in 8..15 (from either page mode), the block issues one read and then one write to that address. The written value is the word read plus one, and ea equals it. done rises four cycles after acceptance.
- R8: The pointer increment wraps modulo 4096, so 7777 octal becomes 0000.
- R9: done is high for exactly one cycle per accepted request. req_ready is 1 only when idle, and a request presented while busy is ignored.
- R10: mem_re and mem_we are never high in the same cycle. The cycle after a read strobe carries no memory strobe and no done.
- R11: A direct reference to an address in 8..15 leaves that memory word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Address of the instruction |
| req_ready | output | 1 | High when idle |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Read data, valid the cycle after mem_re |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 12 | Final operand address, valid with done |

## Verification
The assertions check the following on every cycle:
- read and write strobes never overlap, and a read is followed by a quiet cycle;
- done lasts one cycle;
- each write-back goes to the address read two cycles earlier and is followed by done carrying the written value;
- a direct reference finishes in one cycle;
- page-zero addresses have clear upper bits;
- a rejected opcode leaves the block idle.

Only the bench scenarios can show the rest:
- the actual pointer values returned from memory and the increment across the 4095 to 0 boundary;
- that current-page addressing takes its page from the instruction's own pc at a page edge;
- that a direct reference into the index window leaves memory alone;
- that a request made while busy never starts a second transaction.

// File: rtl/pea_pkg.sv
package pea_pkg;
    parameter int WORD_W    = 12;
    parameter int OFS_W     = 7;
    parameter int OPC_W     = 3;
    parameter int MRI_LIMIT = 6;
    parameter int AUTO_LO   = 8;
    parameter int AUTO_CNT  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_FETCH,
        ST_WRITE,
        ST_DONE
    } pea_state_e;
endpackage

// File: rtl/pea_addr_form.sv
module pea_addr_form #(
    parameter int WORD_W    = pea_pkg::WORD_W,
    parameter int OFS_W     = pea_pkg::OFS_W,
    parameter int OPC_W     = pea_pkg::OPC_W,
    parameter int MRI_LIMIT = pea_pkg::MRI_LIMIT,
    parameter int AUTO_LO   = pea_pkg::AUTO_LO,
    parameter int AUTO_CNT  = pea_pkg::AUTO_CNT
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc,
    output logic              is_mri,
    output logic              indirect,
    output logic              in_window,
    output logic [WORD_W-1:0] addr
);
    localparam int PAGE_W  = WORD_W - OFS_W;
    localparam int AUTO_HI = AUTO_LO + AUTO_CNT - 1;
    localparam int IND_BIT = OFS_W + 1;
    localparam int PG_BIT  = OFS_W;

    logic [OPC_W-1:0]  opcode;
    logic [PAGE_W-1:0] page;
    logic              pc_low_unused;

    assign pc_low_unused = ^pc[OFS_W-1:0];
    assign opcode   = instr[WORD_W-1 -: OPC_W];
    assign is_mri   = opcode < OPC_W'(MRI_LIMIT);
    assign indirect = instr[IND_BIT];

    always_comb begin
        if (instr[PG_BIT]) begin
            page = pc[WORD_W-1:OFS_W];
        end else begin
            page = '0;
        end
        addr      = {page, instr[OFS_W-1:0]};
        in_window = (addr >= WORD_W'(AUTO_LO)) && (addr <= WORD_W'(AUTO_HI));
    end
endmodule

// File: rtl/pea_ptr_inc.sv
module pea_ptr_inc #(
    parameter int WORD_W = pea_pkg::WORD_W
) (
    input  logic [WORD_W-1:0] ptr_in,
    output logic [WORD_W-1:0] ptr_out
);
    // modulo 2**WORD_W: the carry out is dropped
    assign ptr_out = ptr_in + WORD_W'(1);
endmodule

// File: rtl/pea_seq.sv
module pea_seq #(
    parameter int WORD_W = pea_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              indirect,
    input  logic              in_window,
    input  logic [WORD_W-1:0] form_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] inc_val,
    output logic              req_ready,
    output logic              mem_re,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic [WORD_W-1:0] ea
);
    import pea_pkg::*;

    typedef struct packed {
        pea_state_e        st;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] ptr;
        logic              bump;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.addr = form_addr;
                    nxt_d.bump = indirect && in_window;
                    if (indirect) begin
                        nxt_d.st = ST_READ;
                    end else begin
                        nxt_d.ptr = form_addr;
                        nxt_d.st  = ST_DONE;
                    end
                end
            end
            ST_READ: begin
                nxt_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (cur_q.bump) begin
                    nxt_d.ptr = inc_val;
                    nxt_d.st  = ST_WRITE;
                end else begin
                    nxt_d.ptr = mem_rdata;
                    nxt_d.st  = ST_DONE;
                end
            end
            ST_WRITE: begin
                nxt_d.st = ST_DONE;
            end
            ST_DONE: begin
                nxt_d.st = ST_IDLE;
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, addr: '0, ptr: '0, bump: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.st == ST_IDLE);
    assign mem_re    = (cur_q.st == ST_READ);
    assign mem_we    = (cur_q.st == ST_WRITE);
    assign mem_addr  = cur_q.addr;
    assign mem_wdata = cur_q.ptr;
    assign done      = (cur_q.st == ST_DONE);
    assign ea        = cur_q.ptr;

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R10
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re && !mem_we && !done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R7
    wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done && (ea == $past(mem_wdata)));
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
    parameter int WORD_W    = pea_pkg::WORD_W,
    parameter int OFS_W     = pea_pkg::OFS_W,
    parameter int OPC_W     = pea_pkg::OPC_W,
    parameter int MRI_LIMIT = pea_pkg::MRI_LIMIT,
    parameter int AUTO_LO   = pea_pkg::AUTO_LO,
    parameter int AUTO_CNT  = pea_pkg::AUTO_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc,
    output logic              req_ready,
    output logic              mem_re,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] ea
);
    localparam int PAGE_W  = WORD_W - OFS_W;
    localparam int IND_BIT = OFS_W + 1;
    localparam int PG_BIT  = OFS_W;

    logic              is_mri;
    logic              indirect;
    logic              in_window;
    logic [WORD_W-1:0] form_addr;
    logic [WORD_W-1:0] inc_val;
    logic              start;

    pea_addr_form #(
        .WORD_W(WORD_W), .OFS_W(OFS_W), .OPC_W(OPC_W),
        .MRI_LIMIT(MRI_LIMIT), .AUTO_LO(AUTO_LO), .AUTO_CNT(AUTO_CNT)
    ) u_form (
        .instr    (instr),
        .pc       (pc),
        .is_mri   (is_mri),
        .indirect (indirect),
        .in_window(in_window),
        .addr     (form_addr)
    );

    pea_ptr_inc #(.WORD_W(WORD_W)) u_inc (
        .ptr_in (mem_rdata),
        .ptr_out(inc_val)
    );

    assign start = req_valid && is_mri;

    pea_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .indirect (indirect),
        .in_window(in_window),
        .form_addr(form_addr),
        .mem_rdata(mem_rdata),
        .inc_val  (inc_val),
        .req_ready(req_ready),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .done     (done),
        .ea       (ea)
    );

    // R2
    nonmri_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (instr[WORD_W-1 -: OPC_W] >= OPC_W'(MRI_LIMIT)))
        |=> req_ready && !mem_re && !done);

    // R5
    direct_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (instr[WORD_W-1 -: OPC_W] < OPC_W'(MRI_LIMIT))
         && !instr[IND_BIT])
        |=> done && !mem_re && !mem_we);

    // R3
    pagezero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (instr[WORD_W-1 -: OPC_W] < OPC_W'(MRI_LIMIT))
         && !instr[IND_BIT] && !instr[PG_BIT])
        |=> (ea[WORD_W-1 -: PAGE_W] == '0) && (ea[OFS_W-1:0] == $past(instr[OFS_W-1:0])));

    // R6
    ind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (instr[WORD_W-1 -: OPC_W] < OPC_W'(MRI_LIMIT))
         && instr[IND_BIT])
        |=> mem_re && (mem_addr[OFS_W-1:0] == $past(instr[OFS_W-1:0])));

    // R7
    wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr, 2)) && !$past(mem_we));
endmodule

// File: tb/paged_ea_gen_bench.sv
`timescale 1ns/1ps
module paged_ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] pc = '0;
    logic        req_ready, mem_re, mem_we, done;
    logic [11:0] mem_addr, mem_wdata, mem_rdata, ea;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    paged_ea_gen u_paged_ea_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr), .pc(pc),
        .req_ready(req_ready), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .ea(ea)
    );

    // memory model: 256 words, indexed by the low address byte
    logic [11:0] mem [256];
    logic        pl_en = 1'b0;
    logic [11:0] pl_addr = '0, pl_data = '0;
    logic        cnt_clr = 1'b0;
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;

    initial mem_rdata = '0;

    always @(posedge clk) begin
        if (pl_en) mem[pl_addr[7:0]] <= pl_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (cnt_clr) begin
            rd_cnt <= 0; wr_cnt <= 0; done_cnt <= 0;
        end else begin
            rd_cnt   <= rd_cnt + int'(mem_re);
            wr_cnt   <= wr_cnt + int'(mem_we);
            done_cnt <= done_cnt + int'(done);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, expv);
        end
    endtask

    task automatic preload(input logic [11:0] a, input logic [11:0] d);
        @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic clear_counts();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
    endtask

    // issue one request; returns cycles from the accepting edge to done
    task automatic issue(input logic [11:0] ins, input logic [11:0] p, output int lat);
        @(negedge clk);
        req_valid = 1'b1; instr = ins; pc = p;
        lat = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (done) break;
        end
    endtask

    typedef struct packed {
        logic [11:0] ins;
        logic [11:0] p;
        logic [11:0] paddr;
        logic [11:0] pval;
        logic [11:0] exp_ea;
        int          lat;
        int          rd;
        int          wr;
        int          req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{12'o1045, 12'o0200, 12'o0045, 12'o0011, 12'o0045, 1, 0, 0, 3},  // R3 direct page zero
        '{12'o0245, 12'o5432, 12'o0045, 12'o0011, 12'o5445, 1, 0, 0, 4},  // R4 current page
        '{12'o5200, 12'o0377, 12'o0000, 12'o0000, 12'o0200, 1, 0, 0, 4},  // R4 last word of page
        '{12'o3420, 12'o0200, 12'o0020, 12'o6543, 12'o6543, 3, 1, 0, 6},  // R6 just above window
        '{12'o2410, 12'o0600, 12'o0010, 12'o1777, 12'o2000, 4, 1, 1, 7},  // R7 window low edge
        '{12'o4417, 12'o0600, 12'o0017, 12'o7777, 12'o0000, 4, 1, 1, 8},  // R8 wrap at window top
        '{12'o1407, 12'o0600, 12'o0007, 12'o1234, 12'o1234, 3, 1, 0, 6},  // R6 just below window
        '{12'o0612, 12'o0050, 12'o0012, 12'o0100, 12'o0101, 4, 1, 1, 7},  // R7 via current page 0
        '{12'o1610, 12'o0300, 12'o0210, 12'o4321, 12'o4321, 3, 1, 0, 6},  // R6 current page 1
        '{12'o1013, 12'o0600, 12'o0013, 12'o0077, 12'o0013, 1, 0, 0, 11}  // R11 direct into window
    };

    initial begin
        int lat;
        vec_t v;
        string tag;
        logic [11:0] expm;

        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        check(req_ready && !done && !mem_re && !mem_we, "R1 in reset",
              {req_ready, done, mem_re, mem_we}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done && !mem_re && !mem_we, "R1 after reset",
              {req_ready, done, mem_re, mem_we}, 4'b1000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            preload(v.paddr, v.pval);
            clear_counts();
            issue(v.ins, v.p, lat);
            check(ea == v.exp_ea, {tag, " ea"}, ea, v.exp_ea);
            check(lat == v.lat, {tag, " latency"}, lat, v.lat);
            check(rd_cnt == v.rd, {tag, " reads"}, rd_cnt, v.rd);
            check(wr_cnt == v.wr, {tag, " writes"}, wr_cnt, v.wr);
            expm = (v.wr != 0) ? v.exp_ea : v.pval;
            check(mem[v.paddr[7:0]] == expm, {tag, " memory word"}, mem[v.paddr[7:0]], expm);
        end

        // R2: operate and I/O opcodes are ignored
        clear_counts();
        @(negedge clk); req_valid = 1'b1; instr = 12'o6031; pc = 12'o0200;
        @(negedge clk); instr = 12'o7300;
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(done_cnt == 0, "R2 no done", done_cnt, 0);
        check(rd_cnt == 0 && wr_cnt == 0, "R2 no memory cycle", rd_cnt + wr_cnt, 0);
        check(req_ready, "R2 stays ready", req_ready, 1);

        // R9: requests while busy are ignored, done is one cycle
        preload(12'o0010, 12'o0005);
        clear_counts();
        @(negedge clk); req_valid = 1'b1; instr = 12'o2410; pc = 12'o0000;
        @(negedge clk); instr = 12'o1045;
        check(!req_ready, "R9 busy not ready", req_ready, 0);
        @(negedge clk);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        check(done && ea == 12'o0006, "R9 first request result", ea, 12'o0006);
        @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(done_cnt == 1, "R9 single done", done_cnt, 1);
        check(rd_cnt == 1 && wr_cnt == 1, "R10 one read one write", rd_cnt * 8 + wr_cnt, 9);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule